// File: doc/BRIEF.md
# Send-Window Packet Splitter

This block sits on the link where guaranteed-traffic packets leave one time-slotted sub-network and enter the next. The downstream side grants the stream a send window: a number of reserved slots per slot-table turn, each slot carrying one flit. The window is often shorter than a packet that arrives from upstream. The block therefore cuts each packet into pieces that fit the windows. Every piece after the first is led by a rebuilt copy of the original header. In each piece header the length field holds the payload count of that piece. Only the first piece keeps the credit field, and each copy carries a zero credit field.

Two start policies are available. In split mode a header may start in any reserved slot that leaves room for at least one payload flit. In equal-window mode a header waits for the first slot of a window, so a packet no longer than the window is never cut. The window size is a configuration input. A running count of copied headers lets the bandwidth cost of the extra headers be measured. Upstream offers flits on a valid/ready handshake and must supply each packet's body back to back once its header is taken.

Header flit layout: credit in bits [7:0], payload length in bits [15:8], route and queue identifier in bits [31:16]. These are the widths for the default parameters.

Top module: `wsp_window_splitter`

## Requirements
- R1: While reset is asserted, out_valid, out_head and out_tail are 0 and split_count is 0.
- R2: At most one flit leaves per reserved slot. A flit handled in a slot where win_open is 1 appears on the outputs one clock later. No flit appears after a cycle where win_open was 0, and in_ready is 1 only in reserved slots.
- R3: A header whose packet (1 + length flits) fits in the slots left in the current window goes out as a single piece. The piece keeps its length and credit fields, and out_tail marks its last flit.
- R4: A header whose packet does not fit is cut. The first piece keeps the credit field, and its length field becomes (slots left including the current slot) minus 1.
- R5: Each remainder piece starts in the first slot of a later window, behind a copy of the header. The copy keeps bits [31:16], sets credit bits [7:0] to 0, and sets length bits [15:8] to the smaller of the payload still owed and cfg_win minus 1.
- R6: split_count rises by exactly one for each copied header and never changes otherwise.
- R7: With cfg_equal = 1, a header is taken only in a slot where win_first is 1. If that packet fits the window, it leaves as one piece.
- R8: With cfg_equal = 0, a header is not started when fewer than two slots remain in the window. It waits for the next window.
- R9: A non-header flit offered while no packet is open is taken during a reserved slot and discarded, with no output flit and no change to split_count.
- R10: A header with length 0 leaves as a single flit with out_head and out_tail both set.
- R11: Payload flits leave in arrival order and unchanged. Across all pieces, the length fields add up to the original length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_win | input | 8 | Reserved slots per window, at least 2 |
| cfg_equal | input | 1 | 1 selects equal-window start policy |
| win_open | input | 1 | Current cycle is a reserved slot of the outgoing stream |
| win_first | input | 1 | Current reserved slot is the first of its window |
| in_valid | input | 1 | Upstream flit valid |
| in_ready | output | 1 | Upstream flit taken this cycle when valid |
| in_flit | input | 32 | Upstream flit |
| in_head | input | 1 | Upstream flit is a header |
| out_valid | output | 1 | Output flit valid |
| out_flit | output | 32 | Output flit |
| out_head | output | 1 | Output flit is a piece header |
| out_tail | output | 1 | Output flit ends a piece |
| split_count | output | 16 | Number of copied headers sent, wrapping |

## Verification
The hardest situation to reach from the ports is a packet long enough to need three pieces whose header arrives late in a window. In that case the first piece is a single payload flit, and two copied headers must follow in separate windows. The stimulus gets there by running a fixed frame of four reserved slots followed by four closed ones, holding each packet back until a chosen phase of that frame, and then offering it. The table varies the start phase, the length and the start policy. Each packet's pieces, credit fields, lengths, start slot and counter step are then compared with values worked out by hand.

// File: rtl/wsp_pkg.sv
package wsp_pkg;

  // Control states of the splitter
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,  // waiting for a header
    ST_BODY   = 2'd1,  // forwarding payload of the current piece
    ST_RESUME = 2'd2   // remainder owed, copy header pending
  } wsp_state_e;

endpackage

// File: rtl/wsp_slot_tracker.sv
module wsp_slot_tracker #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] cfg_win,
  input  logic             win_open,
  input  logic             win_first,
  output logic [LEN_W-1:0] slots_left
);

  localparam logic [LEN_W-1:0] IDX_MAX = {LEN_W{1'b1}};

  logic [LEN_W-1:0] idx_q;
  logic [LEN_W-1:0] idx_now;
  logic [LEN_W-1:0] idx_d;
  logic             idx_en;

  // Position of the current slot inside its window
  always_comb begin
    idx_now = win_first ? '0 : idx_q;
    if (!win_open)
      slots_left = '0;
    else if (idx_now < cfg_win)
      slots_left = cfg_win - idx_now;
    else
      slots_left = '0;
    idx_en = win_open;
    idx_d  = (idx_now == IDX_MAX) ? idx_now : idx_now + LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idx_q <= '0;
    else if (idx_en)
      idx_q <= idx_d;
  end

  // R2: a window may only begin on a reserved slot
  p_first_in_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    win_first |-> win_open);

endmodule

// File: rtl/wsp_hdr_build.sv
module wsp_hdr_build #(
  parameter int FLIT_W = 32,
  parameter int LEN_W  = 8,
  parameter int CRED_W = 8
) (
  input  logic [FLIT_W-1:0] src_hdr,
  input  logic [LEN_W-1:0]  piece_len,
  input  logic              is_copy,
  output logic [FLIT_W-1:0] piece_hdr
);

  localparam int LEN_LSB = CRED_W;

  // Rewrite the length field; a copied header loses its credit field
  always_comb begin
    piece_hdr = src_hdr;
    piece_hdr[LEN_LSB +: LEN_W] = piece_len;
    if (is_copy)
      piece_hdr[CRED_W-1:0] = '0;
  end

endmodule

// File: rtl/wsp_ctrl.sv
module wsp_ctrl
  import wsp_pkg::*;
#(
  parameter int FLIT_W = 32,
  parameter int LEN_W  = 8,
  parameter int CRED_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_equal,
  input  logic              win_open,
  input  logic              win_first,
  input  logic [LEN_W-1:0]  slots_left,
  input  logic              in_valid,
  input  logic              in_head,
  input  logic [FLIT_W-1:0] in_flit,
  output logic              in_ready,
  output logic              emit,
  output logic              emit_head,
  output logic              emit_tail,
  output logic [FLIT_W-1:0] emit_flit,
  output logic [CNT_W-1:0]  split_cnt
);

  localparam int LEN_LSB = CRED_W;

  wsp_state_e        state_q, state_d;
  logic [FLIT_W-1:0] hdr_q;
  logic              hdr_ld;
  logic [LEN_W-1:0]  left_q, left_d;
  logic [LEN_W-1:0]  piece_q, piece_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  logic [LEN_W-1:0]  room;
  logic              start_ok;
  logic [LEN_W-1:0]  in_len;
  logic [LEN_W-1:0]  owed;
  logic [LEN_W-1:0]  take;
  logic [FLIT_W-1:0] hb_src;
  logic              hb_copy;
  logic [FLIT_W-1:0] hb_out;

  // Budget for the piece that may start in this slot
  always_comb begin
    room     = (slots_left != '0) ? slots_left - LEN_W'(1) : '0;
    start_ok = cfg_equal ? (win_open && win_first) : (slots_left >= LEN_W'(2));
    in_len   = in_flit[LEN_LSB +: LEN_W];
    owed     = (state_q == ST_RESUME) ? left_q : in_len;
    take     = (owed < room) ? owed : room;
    hb_copy  = (state_q == ST_RESUME);
    hb_src   = hb_copy ? hdr_q : in_flit;
  end

  wsp_hdr_build #(
    .FLIT_W (FLIT_W),
    .LEN_W  (LEN_W),
    .CRED_W (CRED_W)
  ) u_hdr (
    .src_hdr   (hb_src),
    .piece_len (take),
    .is_copy   (hb_copy),
    .piece_hdr (hb_out)
  );

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    left_d    = left_q;
    piece_d   = piece_q;
    cnt_d     = cnt_q;
    hdr_ld    = 1'b0;
    in_ready  = 1'b0;
    emit      = 1'b0;
    emit_head = 1'b0;
    emit_tail = 1'b0;
    emit_flit = in_flit;
    case (state_q)
      ST_IDLE: begin
        in_ready = win_open && (!in_head || start_ok);
        if (in_valid && in_ready && in_head) begin
          emit      = 1'b1;
          emit_head = 1'b1;
          emit_flit = hb_out;
          hdr_ld    = 1'b1;
          piece_d   = take;
          left_d    = in_len - take;
          emit_tail = (take == '0);
          if (take != '0)
            state_d = ST_BODY;
        end
      end
      ST_BODY: begin
        in_ready = win_open;
        if (in_valid && win_open) begin
          emit    = 1'b1;
          piece_d = piece_q - LEN_W'(1);
          if (piece_q == LEN_W'(1)) begin
            emit_tail = 1'b1;
            state_d   = (left_q == '0) ? ST_IDLE : ST_RESUME;
          end
        end
      end
      ST_RESUME: begin
        if (start_ok) begin
          emit      = 1'b1;
          emit_head = 1'b1;
          emit_flit = hb_out;
          piece_d   = take;
          left_d    = left_q - take;
          cnt_d     = cnt_q + CNT_W'(1);
          state_d   = ST_BODY;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      piece_q <= '0;
      cnt_q   <= '0;
      hdr_q   <= '0;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
      piece_q <= piece_d;
      cnt_q   <= cnt_d;
      if (hdr_ld)
        hdr_q <= in_flit;
    end
  end

  assign split_cnt = cnt_q;

  // R2: the upstream side is only served in reserved slots
  p_ready_in_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> win_open);

  // R4: a piece header never promises more payload than the window still holds
  p_piece_fits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && emit_head) |-> (emit_flit[LEN_LSB +: LEN_W] < slots_left));

  // R5: copied headers leave without credit
  p_copy_no_credit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && emit_head && state_q == ST_RESUME) |-> (emit_flit[CRED_W-1:0] == '0));

  // R6: the split counter moves by at most one per cycle
  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1))));

  // R7: equal-window mode starts headers only on the first slot
  p_equal_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && emit_head && cfg_equal) |-> win_first);

  // R8: split mode never starts a header in the last slot of a window
  p_late_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && emit_head && !cfg_equal) |-> (slots_left >= LEN_W'(2)));

endmodule

// File: rtl/wsp_window_splitter.sv
module wsp_window_splitter #(
  parameter int FLIT_W = 32,
  parameter int LEN_W  = 8,
  parameter int CRED_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  cfg_win,
  input  logic              cfg_equal,
  input  logic              win_open,
  input  logic              win_first,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FLIT_W-1:0] in_flit,
  input  logic              in_head,
  output logic              out_valid,
  output logic [FLIT_W-1:0] out_flit,
  output logic              out_head,
  output logic              out_tail,
  output logic [CNT_W-1:0]  split_count
);

  logic [1:0]        rst_sync_q;
  logic              rst_s_n;
  logic [LEN_W-1:0]  slots_left;
  logic              emit;
  logic              emit_head;
  logic              emit_tail;
  logic [FLIT_W-1:0] emit_flit;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  wsp_slot_tracker #(
    .LEN_W (LEN_W)
  ) u_slots (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .cfg_win    (cfg_win),
    .win_open   (win_open),
    .win_first  (win_first),
    .slots_left (slots_left)
  );

  wsp_ctrl #(
    .FLIT_W (FLIT_W),
    .LEN_W  (LEN_W),
    .CRED_W (CRED_W),
    .CNT_W  (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .cfg_equal  (cfg_equal),
    .win_open   (win_open),
    .win_first  (win_first),
    .slots_left (slots_left),
    .in_valid   (in_valid),
    .in_head    (in_head),
    .in_flit    (in_flit),
    .in_ready   (in_ready),
    .emit       (emit),
    .emit_head  (emit_head),
    .emit_tail  (emit_tail),
    .emit_flit  (emit_flit),
    .split_cnt  (split_count)
  );

  // Output stage: one registered flit per reserved slot
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      out_valid <= 1'b0;
      out_head  <= 1'b0;
      out_tail  <= 1'b0;
      out_flit  <= '0;
    end else begin
      out_valid <= emit;
      out_head  <= emit && emit_head;
      out_tail  <= emit && emit_tail;
      if (emit)
        out_flit <= emit_flit;
    end
  end

  // R2: nothing leaves unless the previous cycle was a reserved slot
  p_out_after_slot_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    out_valid |-> $past(win_open));

  // R10: a header-only piece is both head and tail, and tails need valid
  p_tail_valid_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (out_head || out_tail) |-> out_valid);

endmodule

// File: tb/wsp_window_splitter_test.sv
module wsp_window_splitter_test;

  localparam int FRAME = 8;
  localparam int OPEN  = 4;

  typedef struct packed {
    logic       eq;
    logic [2:0] ph;
    logic [7:0] len;
    logic [7:0] cred;
    logic [3:0] pieces;
    logic [7:0] first;
    logic [2:0] sph;
  } vec_t;

  // equal, offer phase, length, credit, pieces, first piece length, start phase
  localparam vec_t VECS [9] = '{
    '{1'b0, 3'd0, 8'd2, 8'h15, 4'd1, 8'd2, 3'd0},  // R3 fits
    '{1'b0, 3'd0, 8'd3, 8'h26, 4'd1, 8'd3, 3'd0},  // R3 exact fit
    '{1'b0, 3'd1, 8'd3, 8'h37, 4'd2, 8'd2, 3'd1},  // R4 R5 cut once
    '{1'b0, 3'd3, 8'd2, 8'h48, 4'd1, 8'd2, 3'd0},  // R8 waits
    '{1'b0, 3'd0, 8'd7, 8'h59, 4'd3, 8'd3, 3'd0},  // R5 R11 three pieces
    '{1'b1, 3'd2, 8'd3, 8'h6A, 4'd1, 8'd3, 3'd0},  // R7 waits for first slot
    '{1'b0, 3'd2, 8'd0, 8'h7B, 4'd1, 8'd0, 3'd2},  // R10 header only
    '{1'b1, 3'd0, 8'd5, 8'h8C, 4'd2, 8'd3, 3'd0},  // R7 long packet still cut
    '{1'b0, 3'd2, 8'd6, 8'h9D, 4'd3, 8'd1, 3'd2}   // R4 R5 late start
  };

  logic        clk;
  logic        rst_n;
  logic [7:0]  cfg_win;
  logic        cfg_equal;
  logic        win_open;
  logic        win_first;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_flit;
  logic        in_head;
  logic        out_valid;
  logic [31:0] out_flit;
  logic        out_head;
  logic        out_tail;
  logic [15:0] split_count;

  int checks = 0;
  int errors = 0;

  wsp_window_splitter uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_win     (cfg_win),
    .cfg_equal   (cfg_equal),
    .win_open    (win_open),
    .win_first   (win_first),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_flit     (in_flit),
    .in_head     (in_head),
    .out_valid   (out_valid),
    .out_flit    (out_flit),
    .out_head    (out_head),
    .out_tail    (out_tail),
    .split_count (split_count)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Source and monitor state
  int          fc = 0;
  int          last_ph = 0;
  logic        last_open = 1'b0;
  logic        src_on = 1'b0;
  logic        stray = 1'b0;
  int          idx = 0;
  int          cur_len = 0;
  logic [31:0] cur_hdr = '0;
  logic        acc_last = 1'b0;

  int n_out, n_heads, first_len, sum_len, n_pay, n_tail, head_ph;
  int bad_cred, bad_route, bad_len, bad_order, bad_slot;
  logic [7:0]  exp_cred;
  logic [15:0] exp_route;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    n_out = 0; n_heads = 0; first_len = -1; sum_len = 0; n_pay = 0; n_tail = 0;
    head_ph = -1; bad_cred = 0; bad_route = 0; bad_len = 0; bad_order = 0; bad_slot = 0;
  endtask

  task automatic monitor();
    int plen;
    int expect_len;
    if (out_valid) begin
      n_out++;
      if (!last_open) bad_slot++;
      if (out_tail) n_tail++;
      if (out_head) begin
        n_heads++;
        plen = int'(out_flit[15:8]);
        if (out_flit[31:16] != exp_route) bad_route++;
        if (n_heads == 1) begin
          first_len = plen;
          head_ph   = last_ph;
          if (out_flit[7:0] != exp_cred) bad_cred++;
        end else begin
          if (out_flit[7:0] != 8'h00) bad_cred++;
          expect_len = cur_len - sum_len;
          if (expect_len > OPEN - 1) expect_len = OPEN - 1;
          if (plen != expect_len) bad_len++;
        end
        sum_len += plen;
      end else begin
        n_pay++;
        if (out_flit != 32'hD000_0000 + 32'(n_pay)) bad_order++;
      end
    end
  endtask

  task automatic cycle();
    int ph;
    @(negedge clk);
    monitor();
    ph        = fc % FRAME;
    win_open  = (ph < OPEN);
    win_first = (ph == 0);
    if (stray) begin
      in_valid = 1'b1;
      in_head  = 1'b0;
      in_flit  = 32'hEEEE_0001;
    end else if (src_on && idx <= cur_len) begin
      in_valid = 1'b1;
      in_head  = (idx == 0);
      in_flit  = (idx == 0) ? cur_hdr : 32'hD000_0000 + 32'(idx);
    end else begin
      in_valid = 1'b0;
      in_head  = 1'b0;
      in_flit  = '0;
    end
    #5;
    acc_last = in_valid && in_ready;
    if (acc_last && !stray) idx++;
    last_ph   = ph;
    last_open = win_open;
    fc++;
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cnt_before;
    rst_n     = 1'b0;
    cfg_win   = 8'd4;
    cfg_equal = 1'b0;
    win_open  = 1'b0;
    win_first = 1'b0;
    in_valid  = 1'b0;
    in_head   = 1'b0;
    in_flit   = '0;
    exp_cred  = '0;
    exp_route = '0;
    clear_mon();
    repeat (3) cycle();

    // R1: reset state
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 out_head", int'(out_head), 0);
    chk("R1 out_tail", int'(out_tail), 0);
    chk("R1 split_count", int'(split_count), 0);

    rst_n = 1'b1;
    repeat (FRAME) cycle();

    // Table-driven packets
    for (int v = 0; v < 9; v++) begin
      cfg_equal  = VECS[v].eq;
      cur_len    = int'(VECS[v].len);
      exp_cred   = VECS[v].cred;
      exp_route  = 16'h5A00 + 16'(v);
      cur_hdr    = {exp_route, VECS[v].len, VECS[v].cred};
      idx        = 0;
      clear_mon();
      cnt_before = int'(split_count);
      while ((fc % FRAME) != int'(VECS[v].ph)) cycle();
      src_on = 1'b1;
      while (idx <= cur_len) cycle();
      src_on = 1'b0;
      repeat (3) cycle();
      chk($sformatf("R3 R4 v%0d pieces", v), n_heads, int'(VECS[v].pieces));
      chk($sformatf("R4 v%0d first length", v), first_len, int'(VECS[v].first));
      chk($sformatf("R7 R8 v%0d start phase", v), head_ph, int'(VECS[v].sph));
      chk($sformatf("R4 R5 v%0d credit fields", v), bad_cred, 0);
      chk($sformatf("R5 v%0d route kept", v), bad_route, 0);
      chk($sformatf("R5 v%0d copy lengths", v), bad_len, 0);
      chk($sformatf("R6 v%0d split delta", v), int'(split_count) - cnt_before,
          int'(VECS[v].pieces) - 1);
      chk($sformatf("R10 v%0d tails", v), n_tail, int'(VECS[v].pieces));
      chk($sformatf("R11 v%0d length sum", v), sum_len, cur_len);
      chk($sformatf("R11 v%0d payload count", v), n_pay, cur_len);
      chk($sformatf("R11 v%0d payload order", v), bad_order, 0);
      chk($sformatf("R2 v%0d slot discipline", v), bad_slot, 0);
    end

    // R9: stray payload in a reserved slot is swallowed
    cfg_equal = 1'b0;
    clear_mon();
    cnt_before = int'(split_count);
    while ((fc % FRAME) != 1) cycle();
    stray = 1'b1;
    cycle();
    stray = 1'b0;
    chk("R9 stray taken", int'(acc_last), 1);
    repeat (3) cycle();
    chk("R9 no output", n_out, 0);
    chk("R9 counter unchanged", int'(split_count), cnt_before);

    // R2: nothing is taken in a closed slot
    while ((fc % FRAME) != 5) cycle();
    stray = 1'b1;
    cycle();
    stray = 1'b0;
    chk("R2 closed slot not taken", int'(acc_last), 0);
    repeat (2) cycle();
    chk("R2 closed slot no output", n_out, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule